// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive-buffer descriptors held in system memory. Each table entry describes one buffer: a 32-bit base address and a 32-bit size in 16-bit words. On a host command the block reads the entry at the current read pointer through a memory read port, one field at a time. It then presents the buffer address and word count on its outputs and moves the read pointer to the next entry. The ring wraps when the pointer reaches the programmed end value, not at a power-of-two boundary.

The host programs the ring through a small register port. There are start, end, read and write pointers, each 16 bits, plus an upper address half that is shared by the whole ring. A data-width mode selects 16-bit or 32-bit slots per field, and a byte-order input selects which half of a 32-bit slot holds the data. When the read pointer catches up with the host's write pointer, a sticky exhausted flag warns that the last buffer is now in use. A completed fetch also clears a last-buffer-full flag, which is raised by the receive path, so that reception can resume.

Top module: `rxres_ring`

## Requirements
- R1: After reset, busy, exhausted, irq, last_full and mem_req_valid are 0. buf_addr, buf_words and all five pointer registers are 0.
- R2: A fetch issues exactly four reads, one at a time, at addresses {upper, rdptr} + k*S for k = 0..3. S is 2 in 16-bit mode and 4 in 32-bit mode. A request holds its address until mem_req_ready is seen.
- R3: The four fields are, in order, address low, address high, count low and count high. Each is taken from mem_rsp_data[15:0], except in 32-bit mode with big_endian=1, where it is taken from [31:16]. buf_addr and buf_words update together when the fourth response returns.
- R4: After a fetch the read pointer advances by 8 (16-bit mode) or 16 (32-bit mode), modulo 2^16. If the result equals the end pointer, the start pointer is loaded instead.
- R5: If the new read pointer equals the write pointer, exhausted (STAT bit 0) is set and stays set until the host clears it. irq equals exhausted AND irq_en.
- R6: A write to STAT (address 1) with bit 0 = 1 clears exhausted. If exhausted was set and the block is idle, the write also starts a fetch. If exhausted was clear, the write has no effect.
- R7: Writes to start (2), end (3), read (4) and write (5) pointers clear bits [1:0] in 32-bit mode and bit 0 in 16-bit mode. The upper address register (6) is stored unchanged.
- R8: Writing CTRL (address 0) with bit 0 = 1 starts a fetch. busy is high from the edge after the trigger until the edge that updates the outputs. Triggers that arrive while busy are ignored.
- R9: A last_full_set pulse sets last_full. A completed fetch clears it, and the clear takes priority over a set in the same cycle.
- R10: The read map is: 0 returns busy in bit 0; 1 returns exhausted in bit 0; 2 to 6 return the start, end, read, write and upper registers; 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: 32-bit slots, 0: 16-bit slots |
| big_endian | input | 1 | In 32-bit mode, take fields from the upper half |
| irq_en | input | 1 | Interrupt enable for the exhausted flag |
| last_full_set | input | 1 | Receive path marks the last buffer full |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_rd_addr | input | 3 | Register read address |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| buf_addr | output | 32 | Current buffer base address |
| buf_words | output | 32 | Current buffer word count |
| busy | output | 1 | Fetch in progress |
| exhausted | output | 1 | Ring exhausted flag |
| irq | output | 1 | Interrupt request |
| last_full | output | 1 | Last buffer full flag |

## Verification
A wrong field counter or slot stride shows up as a bad address on mem_req_addr on the first request after the trigger. A wrong half-word select appears in buf_addr or buf_words as soon as busy falls. A wrong wrap or compare shows up in the read pointer readback and the exhausted output in the cycle after completion, and the error then carries into every later fetch address. A stuck state machine shows as busy never falling or as extra requests.

// File: rtl/rxres_ring.sv
module rxres_ring #(
  parameter int PW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_mode,
  input  logic            big_endian,
  input  logic            irq_en,
  input  logic            last_full_set,
  input  logic            reg_wr_en,
  input  logic [2:0]      reg_addr,
  input  logic [PW-1:0]   reg_wdata,
  input  logic [2:0]      reg_rd_addr,
  output logic [PW-1:0]   reg_rdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [2*PW-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [2*PW-1:0] mem_rsp_data,
  output logic [2*PW-1:0] buf_addr,
  output logic [2*PW-1:0] buf_words,
  output logic            busy,
  output logic            exhausted,
  output logic            irq,
  output logic            last_full
);
  localparam int AW = 2 * PW;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [1:0]    fld;
  logic [PW-1:0] start_p, end_p, rd_p, wr_p, upper;
  logic [PW-1:0] hold0, hold1, hold2;

  wire wr_ctl  = reg_wr_en && reg_addr == 3'd0 && reg_wdata[0];
  wire wr_stat = reg_wr_en && reg_addr == 3'd1 && reg_wdata[0];
  wire trig    = st == S_IDLE && (wr_ctl || (wr_stat && exhausted));

  wire [PW-1:0] amask = wide_mode ? ~PW'(3) : ~PW'(1);
  wire [PW-1:0] field = (wide_mode && big_endian) ? mem_rsp_data[AW-1:PW]
                                                  : mem_rsp_data[PW-1:0];
  wire [PW-1:0] adv   = rd_p + (wide_mode ? PW'(16) : PW'(8));
  wire [PW-1:0] nxt   = (adv == end_p) ? start_p : adv;
  wire          done  = st == S_WAIT && mem_rsp_valid && fld == 2'd3;

  assign busy          = st != S_IDLE;
  assign mem_req_valid = st == S_REQ;
  assign mem_req_addr  = {upper, rd_p} + (AW'(fld) << (wide_mode ? 2 : 1));
  assign irq           = exhausted & irq_en;

  always_comb begin
    case (reg_rd_addr)
      3'd0:    reg_rdata = PW'(busy);
      3'd1:    reg_rdata = PW'(exhausted);
      3'd2:    reg_rdata = start_p;
      3'd3:    reg_rdata = end_p;
      3'd4:    reg_rdata = rd_p;
      3'd5:    reg_rdata = wr_p;
      3'd6:    reg_rdata = upper;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      fld       <= '0;
      start_p   <= '0;
      end_p     <= '0;
      rd_p      <= '0;
      wr_p      <= '0;
      upper     <= '0;
      hold0     <= '0;
      hold1     <= '0;
      hold2     <= '0;
      buf_addr  <= '0;
      buf_words <= '0;
      exhausted <= 1'b0;
      last_full <= 1'b0;
    end else begin
      if (reg_wr_en) begin
        case (reg_addr)
          3'd2: start_p <= reg_wdata & amask;
          3'd3: end_p   <= reg_wdata & amask;
          3'd4: rd_p    <= reg_wdata & amask;
          3'd5: wr_p    <= reg_wdata & amask;
          3'd6: upper   <= reg_wdata;
          default: ;
        endcase
      end
      if (wr_stat) exhausted <= 1'b0;
      if (last_full_set) last_full <= 1'b1;

      case (st)
        S_IDLE: if (trig) begin
          st  <= S_REQ;
          fld <= '0;
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          case (fld)
            2'd0: hold0 <= field;
            2'd1: hold1 <= field;
            2'd2: hold2 <= field;
            default: ;
          endcase
          if (done) begin
            buf_addr  <= {hold1, hold0};
            buf_words <= {field, hold2};
            rd_p      <= nxt;
            if (nxt == wr_p) exhausted <= 1'b1;
            last_full <= 1'b0;
            st        <= S_IDLE;
          end else begin
            fld <= fld + 2'd1;
            st  <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxres_ring_chk.sv
module rxres_ring_chk #(
  parameter int PW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wide_mode,
  input logic            irq_en,
  input logic            reg_wr_en,
  input logic [2:0]      reg_addr,
  input logic [PW-1:0]   reg_wdata,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [2*PW-1:0] mem_req_addr,
  input logic            busy,
  input logic            exhausted,
  input logic            irq,
  input logic            last_full
);
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2
  AST_WIDE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && wide_mode |-> mem_req_addr[1:0] == 2'b00); // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> exhausted && irq_en); // R5
  AST_EXH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted && !(reg_wr_en && reg_addr == 3'd1 && reg_wdata[0]) |=> exhausted); // R5
  AST_FULL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !last_full); // R9
endmodule

bind rxres_ring rxres_ring_chk #(.PW(PW)) u_chk (.*);

// File: tb/rxres_ring_tb.sv
`timescale 1ns/1ps
module rxres_ring_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0, big_endian = 1'b0, irq_en = 1'b0, last_full_set = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0, reg_rd_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] buf_addr, buf_words;
  logic        busy, exhausted, irq, last_full;
  logic        ready_ctl = 1'b1;
  int          n_chk = 0, n_err = 0, req_cnt = 0;
  logic [31:0] req_log [4];

  assign mem_req_ready = ready_ctl;

  always #2.5 clk = ~clk;

  rxres_ring u_dut (.*);

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= {~mem_req_addr[15:0], mem_req_addr[15:0] ^ 16'h5A5A};
      req_log[req_cnt[1:0]] <= mem_req_addr;
      req_cnt <= req_cnt + 1;
    end
  end

  typedef struct packed {
    logic wide; logic be;
    logic [15:0] st; logic [15:0] en; logic [15:0] rd; logic [15:0] wr; logic [15:0] up;
    logic [15:0] exp_rd; logic exp_exh;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 1'b0, 16'h0100, 16'h0140, 16'h0100, 16'h0120, 16'h0001, 16'h0108, 1'b0},
    '{1'b0, 1'b0, 16'h0100, 16'h0140, 16'h0138, 16'h0100, 16'h0002, 16'h0100, 1'b1},
    '{1'b1, 1'b1, 16'h0200, 16'h0240, 16'h0230, 16'h0300, 16'h0003, 16'h0200, 1'b0},
    '{1'b1, 1'b0, 16'h0200, 16'h0240, 16'h0210, 16'h0220, 16'h0004, 16'h0220, 1'b1},
    '{1'b1, 1'b1, 16'h0040, 16'h0000, 16'hFFF0, 16'h0000, 16'h0005, 16'h0040, 1'b0}
  };

  function automatic logic [15:0] fval(logic [31:0] a, logic w, logic b);
    return (w && b) ? ~a[15:0] : (a[15:0] ^ 16'h5A5A);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    reg_rd_addr = a; #0.1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && busy; i++) @(negedge clk);
  endtask

  task automatic setup(vec_t v);
    do_reset();
    wide_mode = v.wide; big_endian = v.be;
    wr(3'd2, v.st); wr(3'd3, v.en); wr(3'd4, v.rd); wr(3'd5, v.wr); wr(3'd6, v.up);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [15:0] r;
    logic [31:0] base;
    int c0;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 exhausted", exhausted, 0);
    check("R1 irq", irq, 0);
    check("R1 last_full", last_full, 0);
    check("R1 req_valid", mem_req_valid, 0);
    check("R1 buf_addr", buf_addr, 0);
    check("R1 buf_words", buf_words, 0);
    for (int a = 2; a <= 6; a++) begin rd(3'(a), r); check("R1 ptr", r, 0); end

    foreach (VECS[i]) begin
      setup(VECS[i]);
      c0 = req_cnt;
      wr(3'd0, 16'h0001);
      check("R8 busy after trigger", busy, 1);
      wait_idle();
      base = {VECS[i].up, VECS[i].rd};
      for (int k = 0; k < 4; k++)
        check("R2 request address", req_log[(c0 + k) % 4],
              base + 32'(k) * (VECS[i].wide ? 4 : 2));
      check("R2 request count", req_cnt - c0, 4);
      check("R3 buf_addr", buf_addr,
            {fval(base + (VECS[i].wide ? 4 : 2), VECS[i].wide, VECS[i].be),
             fval(base, VECS[i].wide, VECS[i].be)});
      check("R3 buf_words", buf_words,
            {fval(base + (VECS[i].wide ? 12 : 6), VECS[i].wide, VECS[i].be),
             fval(base + (VECS[i].wide ? 8 : 4), VECS[i].wide, VECS[i].be)});
      rd(3'd4, r); check("R4 read pointer", r, VECS[i].exp_rd);
      check("R5 exhausted", exhausted, VECS[i].exp_exh);
      rd(3'd1, r); check("R10 stat read", r, 16'(VECS[i].exp_exh));
    end

    // R7 alignment
    do_reset();
    wide_mode = 1'b1; wr(3'd2, 16'h0123); rd(3'd2, r); check("R7 wide start", r, 16'h0120);
    wr(3'd5, 16'hFFFF); rd(3'd5, r); check("R7 wide wrptr", r, 16'hFFFC);
    wide_mode = 1'b0; wr(3'd3, 16'h0123); rd(3'd3, r); check("R7 narrow end", r, 16'h0122);
    wr(3'd6, 16'hABCD); rd(3'd6, r); check("R7 upper unmasked", r, 16'hABCD);
    rd(3'd7, r); check("R10 unused reads zero", r, 0);

    // R5 irq gating, R6 W1C refetch
    setup(VECS[1]);
    wr(3'd0, 16'h0001); wait_idle();
    check("R5 irq masked", irq, 0);
    irq_en = 1'b1; #0.1;
    check("R5 irq enabled", irq, 1);
    c0 = req_cnt;
    wr(3'd1, 16'h0001);
    check("R6 exhausted cleared", exhausted, 0);
    check("R6 fetch started", busy, 1);
    wait_idle();
    rd(3'd4, r); check("R6 refetch pointer", r, 16'h0108);
    check("R6 refetch reads", req_cnt - c0, 4);
    wr(3'd1, 16'h0001);
    check("R6 no fetch when clear", busy, 0);
    repeat (3) @(negedge clk);
    rd(3'd4, r); check("R6 pointer unchanged", r, 16'h0108);
    irq_en = 1'b0;

    // R8 stalled request, retrigger ignored; R9 last_full
    @(negedge clk); last_full_set = 1'b1; @(negedge clk); last_full_set = 1'b0;
    check("R9 last_full set", last_full, 1);
    ready_ctl = 1'b0; c0 = req_cnt;
    wr(3'd0, 16'h0001);
    repeat (3) @(negedge clk);
    check("R8 busy while stalled", busy, 1);
    check("R2 request held", mem_req_valid, 1);
    check("R2 held address", mem_req_addr, {16'h0002, 16'h0108});
    wr(3'd0, 16'h0001);
    ready_ctl = 1'b1;
    wait_idle();
    repeat (5) @(negedge clk);
    check("R8 busy done", busy, 0);
    rd(3'd4, r); check("R8 single advance", r, 16'h0110);
    check("R8 single fetch reads", req_cnt - c0, 4);
    check("R9 last_full cleared", last_full, 0);

    finish_up();
  end
endmodule